// File: doc/BRIEF.md
# Attribute-Masked Control/Status Register Bank

This block is a bank of 32-bit control and status registers behind a simple single-cycle bus port. Every register has its own set of per-bit attribute masks, fixed at elaboration: read-only, write-one-to-clear, reserved, clear-on-read and unimplemented. Each register also has a reset value. A request carries a read/write flag, a byte address, a write word and an access size in bytes. The bank merges written data according to the attributes. It returns read data limited to the access size and clears clear-on-read bits as a side effect of a read.

Accesses that hit no defined address are reported on an error output. Writes that try to change reserved bits, and writes that set unimplemented bits, are each reported on an output of their own. All responses and error indications are registered and appear exactly one cycle after the request. The register count, the address of each register, the masks and the reset values are all parameters.

Top module: `csr_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every register holds its own reset value. Before the first request, `rsp_valid` and the three error outputs are 0.
- R2: An access enables the low min(size,4)×8 bits, counted from bit 0. A size of 0 enables no bit, and sizes 4 to 7 all enable the full 32 bits.
- R3: A write to a mapped register leaves four kinds of bit at their old value: read-only, write-one-to-clear and reserved bits, and every bit outside the enable mask. Every other bit takes the written value.
- R4: After the merge, each write-one-to-clear bit for which the write word holds a 1 is stored as 0. This applies whatever the access size.
- R5: A read to a mapped register raises `rsp_valid` in the next cycle. `rsp_rdata` then holds the pre-read stored value ANDed with the enable mask.
- R6: A read to a mapped register clears the stored clear-on-read bits that lie inside the enable mask. The data returned for that read still shows those bits as they were before the clear.
- R7: A read or write whose address equals no register address changes no register. It pulses `err_unmapped` in the next cycle, and it never raises `err_reserved` or `err_unimpl`. Such a read returns `rsp_valid` with data 0.
- R8: A mapped write raises `err_reserved` in the next cycle when ((stored value XOR write word) AND reserved mask) is nonzero. The reserved bits still keep their stored value.
- R9: A mapped write raises `err_unimpl` in the next cycle when (write word AND unimplemented mask) is nonzero, whatever the access size.
- R10: Writes never raise `rsp_valid`. A cycle without a request is followed by a cycle with `rsp_valid` and all error outputs at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| err_unmapped | output | 1 | Pulse: the access hit no register |
| err_reserved | output | 1 | Pulse: a write tried to change reserved bits |
| err_unimpl | output | 1 | Pulse: a write set unimplemented bits |

## Verification
The assertions assume that each request lasts one cycle and is fully described by the request inputs sampled at that edge. They also assume that a read and a write never target a register in the same cycle, since the port carries only one operation. The bench drives every request on the falling edge, holds it for exactly one cycle and then returns to idle. It sweeps all eight size codes, several data patterns on every register and all 256 addresses, so no stimulus falls outside these assumptions.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BYTES_W = WORD_W / 8;

  typedef logic [WORD_W-1:0] word_t;

  // Enable mask for an access: low bytes up to the clamped size.
  function automatic word_t size_to_mask(input logic [2:0] size);
    word_t mask;
    mask = '0;
    for (int b = 0; b < BYTES_W; b++) begin
      if (32'(size) > b) begin
        mask[b*8 +: 8] = 8'hFF;
      end
    end
    return mask;
  endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [NUM_REGS-1:0][31:0] REG_ADDR = '0,
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] hit_vec,
  output logic                hit_any,
  output logic [IDX_W-1:0]    hit_idx
);

  // One comparator per register against its full byte address.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
    assign hit_vec[g] = (addr == REG_ADDR[g][ADDR_W-1:0]);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit_vec[i]) begin
        hit_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/csr_reg_slice.sv
module csr_reg_slice
  import csr_bank_pkg::*;
#(
  parameter word_t RESET_VAL = '0,
  parameter word_t RO_BITS   = '0,
  parameter word_t W1C_BITS  = '0,
  parameter word_t RSVD_BITS = '0,
  parameter word_t COR_BITS  = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  rd_en,
  input  word_t wr_data,
  input  word_t en_mask,
  output word_t value_q
);

  word_t keep_bits;
  word_t merged;
  word_t value_d;
  logic  value_ce;

  // Next-state: attribute-aware merge on write, clear-on-read on read.
  always_comb begin
    keep_bits = RO_BITS | W1C_BITS | RSVD_BITS | ~en_mask;
    merged    = (wr_data & ~keep_bits) | (value_q & keep_bits);
    merged    = merged & ~(wr_data & W1C_BITS);
    value_d   = value_q;
    if (wr_en) begin
      value_d = merged;
    end else if (rd_en) begin
      value_d = value_q & ~(COR_BITS & en_mask);
    end
  end

  assign value_ce = wr_en | rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= RESET_VAL;
    end else if (value_ce) begin
      value_q <= value_d;
    end
  end

endmodule

// File: rtl/csr_err_detect.sv
module csr_err_detect
  import csr_bank_pkg::*;
(
  input  logic  wr_hit,
  input  word_t old_val,
  input  word_t wr_data,
  input  word_t rsvd_bits,
  input  word_t unimp_bits,
  output logic  rsvd_viol,
  output logic  unimp_touch
);

  word_t rsvd_diff;
  word_t unimp_set;

  always_comb begin
    rsvd_diff   = (old_val ^ wr_data) & rsvd_bits;
    unimp_set   = wr_data & unimp_bits;
    rsvd_viol   = wr_hit & (|rsvd_diff);
    unimp_touch = wr_hit & (|unimp_set);
  end

endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [NUM_REGS-1:0][31:0] REG_ADDR   = {32'h10, 32'h08, 32'h04, 32'h00},
  parameter logic [NUM_REGS-1:0][31:0] RESET_VAL  = {32'h5A5A_5A5A, 32'hABCD_F0F0, 32'hA500_0000, 32'h1234_5678},
  parameter logic [NUM_REGS-1:0][31:0] RO_MASK    = {32'h0000_FF00, 32'h0000_0000, 32'hFF00_0000, 32'h0000_0000},
  parameter logic [NUM_REGS-1:0][31:0] W1C_MASK   = {32'h0000_0000, 32'h0000_FFFF, 32'h0000_0000, 32'h0000_0000},
  parameter logic [NUM_REGS-1:0][31:0] RSVD_MASK  = {32'h0000_0000, 32'h0000_0000, 32'h00F0_0000, 32'h0000_0000},
  parameter logic [NUM_REGS-1:0][31:0] COR_MASK   = {32'h0000_00FF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
  parameter logic [NUM_REGS-1:0][31:0] UNIMP_MASK = {32'h0000_0000, 32'h0000_0000, 32'h000F_0000, 32'h0000_0000},
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              err_unmapped,
  output logic              err_reserved,
  output logic              err_unimpl
);

  logic [NUM_REGS-1:0]       hit_vec;
  logic                      hit_any;
  logic [IDX_W-1:0]          hit_idx;
  logic [NUM_REGS-1:0][31:0] reg_q;
  word_t                     en_mask;
  word_t                     sel_val;
  word_t                     sel_rsvd;
  word_t                     sel_unimp;
  logic                      is_wr;
  logic                      is_rd;
  logic                      wr_hit;
  logic                      rsvd_viol;
  logic                      unimp_touch;

  // Response next-state
  logic  rsp_valid_d;
  word_t rsp_rdata_d;
  logic  rdata_ce;
  logic  err_unmapped_d;
  logic  err_reserved_d;
  logic  err_unimpl_d;

  assign en_mask = size_to_mask(req_size);
  assign is_wr   = req_valid & req_write;
  assign is_rd   = req_valid & ~req_write;
  assign wr_hit  = is_wr & hit_any;

  csr_addr_decode #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
  ) i_decode (
    .addr    (req_addr),
    .hit_vec (hit_vec),
    .hit_any (hit_any),
    .hit_idx (hit_idx)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    csr_reg_slice #(
      .RESET_VAL (RESET_VAL[g]),
      .RO_BITS   (RO_MASK[g]),
      .W1C_BITS  (W1C_MASK[g]),
      .RSVD_BITS (RSVD_MASK[g]),
      .COR_BITS  (COR_MASK[g])
    ) i_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (is_wr & hit_vec[g]),
      .rd_en   (is_rd & hit_vec[g]),
      .wr_data (req_wdata),
      .en_mask (en_mask),
      .value_q (reg_q[g])
    );
  end

  // Selected register and its error-relevant masks
  always_comb begin
    sel_val   = '0;
    sel_rsvd  = '0;
    sel_unimp = '0;
    if (hit_any) begin
      sel_val   = reg_q[hit_idx];
      sel_rsvd  = RSVD_MASK[hit_idx];
      sel_unimp = UNIMP_MASK[hit_idx];
    end
  end

  csr_err_detect i_err (
    .wr_hit      (wr_hit),
    .old_val     (sel_val),
    .wr_data     (req_wdata),
    .rsvd_bits   (sel_rsvd),
    .unimp_bits  (sel_unimp),
    .rsvd_viol   (rsvd_viol),
    .unimp_touch (unimp_touch)
  );

  always_comb begin
    rsp_valid_d    = is_rd;
    rdata_ce       = is_rd;
    rsp_rdata_d    = hit_any ? (sel_val & en_mask) : '0;
    err_unmapped_d = req_valid & ~hit_any;
    err_reserved_d = rsvd_viol;
    err_unimpl_d   = unimp_touch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      err_unmapped <= 1'b0;
      err_reserved <= 1'b0;
      err_unimpl   <= 1'b0;
    end else begin
      rsp_valid    <= rsp_valid_d;
      err_unmapped <= err_unmapped_d;
      err_reserved <= err_reserved_d;
      err_unimpl   <= err_unimpl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (rdata_ce) begin
      rsp_rdata <= rsp_rdata_d;
    end
  end

endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk
  import csr_bank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [NUM_REGS-1:0][31:0] RO_MASK   = '0,
  parameter logic [NUM_REGS-1:0][31:0] RSVD_MASK = '0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_write,
  input logic [2:0]                req_size,
  input logic                      rsp_valid,
  input logic [31:0]               rsp_rdata,
  input logic                      err_unmapped,
  input logic                      err_reserved,
  input logic                      err_unimpl,
  input logic [NUM_REGS-1:0][31:0] reg_q
);

  p_rsp_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  p_write_no_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_valid);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !err_unmapped && !err_reserved && !err_unimpl));

  p_size_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rdata & ~size_to_mask($past(req_size))) == 32'h0));

  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && err_unmapped) |-> (rsp_rdata == 32'h0));

  p_unmapped_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_unmapped |-> (!err_reserved && !err_unimpl));

  p_rsvd_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_reserved |-> $past(req_valid && req_write));

  p_unimp_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_unimpl |-> $past(req_valid && req_write));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hold
    p_ro_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(reg_q[g] & RO_MASK[g]));

    p_rsvd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(reg_q[g] & RSVD_MASK[g]));
  end

endmodule

bind csr_bank csr_bank_chk #(
  .NUM_REGS  (NUM_REGS),
  .ADDR_W    (ADDR_W),
  .RO_MASK   (RO_MASK),
  .RSVD_MASK (RSVD_MASK)
) i_csr_bank_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_size     (req_size),
  .rsp_valid    (rsp_valid),
  .rsp_rdata    (rsp_rdata),
  .err_unmapped (err_unmapped),
  .err_reserved (err_reserved),
  .err_unimpl   (err_unimpl),
  .reg_q        (reg_q)
);

// File: tb/test_csr_bank.sv
module test_csr_bank;

  localparam int NR = 4;
  localparam logic [NR-1:0][31:0] T_ADDR  = {32'h10, 32'h08, 32'h04, 32'h00};
  localparam logic [NR-1:0][31:0] T_RST   = {32'h5A5A_5A5A, 32'hABCD_F0F0, 32'hA500_0000, 32'h1234_5678};
  localparam logic [NR-1:0][31:0] T_RO    = {32'h0000_FF00, 32'h0000_0000, 32'hFF00_0000, 32'h0000_0000};
  localparam logic [NR-1:0][31:0] T_W1C   = {32'h0000_0000, 32'h0000_FFFF, 32'h0000_0000, 32'h0000_0000};
  localparam logic [NR-1:0][31:0] T_RSVD  = {32'h0000_0000, 32'h0000_0000, 32'h00F0_0000, 32'h0000_0000};
  localparam logic [NR-1:0][31:0] T_COR   = {32'h0000_00FF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000};
  localparam logic [NR-1:0][31:0] T_UNIMP = {32'h0000_0000, 32'h0000_0000, 32'h000F_0000, 32'h0000_0000};

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [7:0]  req_addr;
  logic [2:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        err_unmapped;
  logic        err_reserved;
  logic        err_unimpl;

  int n_checks;
  int n_fail;
  bit done;
  logic [31:0] model [NR];

  csr_bank #(
    .NUM_REGS (NR), .ADDR_W (8), .REG_ADDR (T_ADDR), .RESET_VAL (T_RST),
    .RO_MASK (T_RO), .W1C_MASK (T_W1C), .RSVD_MASK (T_RSVD),
    .COR_MASK (T_COR), .UNIMP_MASK (T_UNIMP)
  ) i_csr_bank (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
    .req_addr (req_addr), .req_size (req_size), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .err_unmapped (err_unmapped),
    .err_reserved (err_reserved), .err_unimpl (err_unimpl)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] emask(input logic [2:0] sz);
    int n;
    n = (sz > 3'd4) ? 4 : int'(sz);
    return (n == 4) ? 32'hFFFF_FFFF : 32'((64'h1 << (n * 8)) - 64'h1);
  endfunction

  function automatic int find_reg(input logic [7:0] a);
    for (int i = 0; i < NR; i++) if (T_ADDR[i][7:0] == a) return i;
    return -1;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
    int idx;
    logic [31:0] keep, nv, e_rsvd, e_unimp;
    idx = find_reg(a);
    e_rsvd = 0; e_unimp = 0; nv = 0;
    if (idx >= 0) begin
      e_rsvd  = 32'(|((model[idx] ^ d) & T_RSVD[idx]));
      e_unimp = 32'(|(d & T_UNIMP[idx]));
      keep = T_RO[idx] | T_W1C[idx] | T_RSVD[idx] | ~emask(sz);
      nv = (d & ~keep) | (model[idx] & keep);
      nv = nv & ~(d & T_W1C[idx]);
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R10", "rsp_valid after write", 32'(rsp_valid), 32'h0);
    check("R7", "err_unmapped on write", 32'(err_unmapped), (idx < 0) ? 32'h1 : 32'h0);
    check("R8", "err_reserved", 32'(err_reserved), e_rsvd);
    check("R9", "err_unimpl", 32'(err_unimpl), e_unimp);
    if (idx >= 0) model[idx] = nv;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [2:0] sz, input string req);
    int idx;
    logic [31:0] exp;
    idx = find_reg(a);
    exp = (idx >= 0) ? (model[idx] & emask(sz)) : 32'h0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz; req_wdata = 32'h0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R5", "rsp_valid after read", 32'(rsp_valid), 32'h1);
    check(req, "rsp_rdata", rsp_rdata, exp);
    check("R7", "err_unmapped on read", 32'(err_unmapped), (idx < 0) ? 32'h1 : 32'h0);
    check("R10", "write errors on read", {30'h0, err_reserved, err_unimpl}, 32'h0);
    if (idx >= 0) model[idx] = model[idx] & ~(T_COR[idx] & emask(sz));
  endtask

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000;
    pats[2] = 32'hA5C3_3C5A; pats[3] = 32'h5A3C_C3A5;
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_size = '0; req_wdata = '0;
    for (int i = 0; i < NR; i++) model[i] = T_RST[i];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet outputs after reset, then reset values read back
    check("R1", "outputs idle after reset",
          {28'h0, rsp_valid, err_unmapped, err_reserved, err_unimpl}, 32'h0);
    for (int i = 0; i < NR; i++) do_read(T_ADDR[i][7:0], 3'd4, "R1");
    // R4: w1c bits outside the 1-byte enable mask still cleared
    do_write(T_ADDR[2][7:0], 3'd1, 32'h0000_F000);
    do_read(T_ADDR[2][7:0], 3'd4, "R4");
    check("R4", "w1c literal", model[2], 32'hABCD_00F0);
    // R6: clear-on-read inside mask, returned value is pre-clear
    do_write(T_ADDR[3][7:0], 3'd4, 32'h0000_00AA);
    do_read(T_ADDR[3][7:0], 3'd1, "R6");
    do_read(T_ADDR[3][7:0], 3'd4, "R6");
    do_write(T_ADDR[3][7:0], 3'd4, 32'h0000_0077);
    do_read(T_ADDR[3][7:0], 3'd0, "R6");
    do_read(T_ADDR[3][7:0], 3'd4, "R6");
    // R3 / R8 / R9: every register, every size code, several patterns
    for (int i = 0; i < NR; i++)
      for (int s = 0; s < 8; s++)
        for (int p = 0; p < 4; p++) begin
          do_write(T_ADDR[i][7:0], 3'(s), pats[p] ^ {8'(s), 8'(s), 8'(s), 8'(s)});
          do_read(T_ADDR[i][7:0], 3'd4, "R3");
        end
    // R2: read each register at each size code
    for (int i = 0; i < NR; i++)
      for (int s = 0; s < 8; s++) begin
        do_write(T_ADDR[i][7:0], 3'd4, pats[2]);
        do_read(T_ADDR[i][7:0], 3'(s), "R2");
      end
    // R7: all 256 addresses
    for (int a = 0; a < 256; a++) begin
      if (find_reg(8'(a)) < 0) do_write(8'(a), 3'd4, 32'hFFFF_FFFF);
      do_read(8'(a), 3'd4, "R7");
    end
    for (int i = 0; i < NR; i++) do_read(T_ADDR[i][7:0], 3'd4, "R7");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule